// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one local processor's memory port and supplies the atomic half of a load-linked / store-conditional pair. Every load-linked request records the word address it reads as the single live reservation. A later store-conditional is allowed to write memory only if that reservation still names the same word. Each such request is answered with a success or failure flag. Only one reservation exists at a time. A newer load-linked overwrites the older one.

Other agents' writes and invalidations arrive on a snoop input. When a snooped address equals the stored reservation, the stored address is forced to zero. Zero is therefore the "no reservation" code, and word address 0 cannot serve as a synchronization word. The reservation is never tracked with a separate valid flag. A store-conditional fails whenever the stored address differs from its own address, and the stored address is zero whenever it has been cleared.

The local request channel carries an opcode, an address and write data, qualified by `req_valid`. The block never applies back-pressure: every valid request is taken in the cycle it is presented, so the channel has no ready signal. Every memory command and result is registered and appears one cycle after the request. Within one cycle a snoop is ordered before the local request. A snoop hit therefore defeats a store-conditional to the same word in the same cycle, but it does not undo a load-linked presented in that same cycle.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the reservation is empty and all outputs (`mem_rd_en`, `mem_wr_en`, `sc_done`, `sc_ok`) are 0.
- R2: A store-conditional (opcode 3) to the address of the last load-linked (opcode 2) succeeds if no clearing event has happened in between. One cycle after the request, `sc_done`=1, `sc_ok`=1 and `mem_wr_en`=1, with `mem_addr` and `mem_wdata` taken from the request.
- R3: A store-conditional to any address other than the reservation fails. One cycle later `sc_done`=1, `sc_ok`=0 and `mem_wr_en`=0.
- R4: A load-linked replaces any earlier reservation. A store-conditional to the earlier address then fails.
- R5: A snoop (`snp_valid`=1) whose address equals the reservation clears it, and a later store-conditional to that address fails. A snoop to a different address leaves the reservation intact.
- R6: A store-conditional consumes the reservation whether it succeeds or fails. A second store-conditional to the same address fails.
- R7: Address 0 is never a live reservation. A load-linked to 0 followed by a store-conditional to 0 fails.
- R8: A snoop hit and a store-conditional to the same reserved address in the same cycle make the store-conditional fail, with no memory write.
- R9: A plain store (opcode 1) is always written (`mem_wr_en`=1 one cycle later). If its address equals the reservation, the reservation is cleared. Otherwise the reservation is kept.
- R10: A plain load (opcode 0) or a load-linked raises `mem_rd_en` one cycle later, with `mem_wr_en`=0 and `sc_done`=0. `sc_done` rises only for store-conditionals.
- R11: A snoop to address A presented in the same cycle as a load-linked to A does not cancel the new reservation. A later store-conditional to A succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present this cycle (always accepted) |
| req_op | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| snp_valid | input | 1 | Remote write or invalidation seen this cycle |
| snp_addr | input | ADDR_W | Address of the snooped event |
| mem_rd_en | output | 1 | Registered memory read command |
| mem_wr_en | output | 1 | Registered memory write command |
| mem_addr | output | ADDR_W | Registered memory address |
| mem_wdata | output | DATA_W | Registered memory write data |
| sc_done | output | 1 | A store-conditional result is presented this cycle |
| sc_ok | output | 1 | Store-conditional result: 1 success, 0 failure |

## Verification
The bench sweeps every load-linked address, every snoop address (or no snoop) and every store-conditional address of a 4-bit address space. It therefore catches a monitor that lets address 0 act as a live reservation, or that ignores snoops, or that compares only part of the address. Directed sequences cover cases where a broken design would write memory it should not. These are a stale reservation after a newer load-linked, a second store-conditional that reuses a consumed reservation, a same-cycle snoop that loses to the store-conditional, and a local store that fails to clear the reservation. The reverse ordering is also covered: a same-cycle snoop that wrongly cancels a fresh load-linked would make a valid store-conditional fail.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_addr_cmp.sv
module llsc_addr_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] probe,
  input  logic [ADDR_W-1:0] held,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] EMPTY = '0;
  // A held value of zero means "no reservation" and never matches.
  assign hit = (probe == held) && (held != EMPTY);
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_hit,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  output logic [ADDR_W-1:0] resv_q
);
  logic [ADDR_W-1:0] resv_d;

  always_comb begin
    resv_d = resv_q;
    if (snoop_hit) resv_d = '0;
    if (clr_en)    resv_d = '0;
    if (set_en)    resv_d = set_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resv_q <= '0;
    else        resv_q <= resv_d;
  end

  // R5: a snoop hit with no new link leaves the reservation empty
  p_snoop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !set_en) |=> (resv_q == '0));

  // R4: a link records its address
  p_link_records_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (resv_q == $past(set_addr)));
endmodule

// File: rtl/llsc_out_stage.sv
module llsc_out_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              cond_req,
  input  logic              cond_pass,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sc_done,
  output logic              sc_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      sc_done   <= 1'b0;
      sc_ok     <= 1'b0;
    end else begin
      mem_rd_en <= rd_req;
      mem_wr_en <= wr_req || (cond_req && cond_pass);
      mem_addr  <= addr_in;
      mem_wdata <= data_in;
      sc_done   <= cond_req;
      sc_ok     <= cond_req && cond_pass;
    end
  end

  // R3: a failed conditional never writes
  p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && !sc_ok) |-> !mem_wr_en);

  // R10: result strobe only follows a conditional request
  p_done_only_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(cond_req));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sc_done,
  output logic              sc_ok
);
  llsc_op_e          op;
  logic [ADDR_W-1:0] resv_q;
  logic [ADDR_W-1:0] resv_after_snoop;
  logic              snp_match, snoop_hit, local_hit;
  logic              is_load, is_store, is_link, is_cond;

  assign op       = llsc_op_e'(req_op);
  assign is_load  = req_valid && (op == OP_LOAD);
  assign is_store = req_valid && (op == OP_STORE);
  assign is_link  = req_valid && (op == OP_LINK);
  assign is_cond  = req_valid && (op == OP_COND);

  llsc_addr_cmp #(.ADDR_W(ADDR_W)) u_snp_cmp (
    .probe(snp_addr), .held(resv_q), .hit(snp_match)
  );
  assign snoop_hit = snp_valid && snp_match;

  // Snoop is ordered ahead of the local request in the same cycle.
  assign resv_after_snoop = snoop_hit ? '0 : resv_q;

  llsc_addr_cmp #(.ADDR_W(ADDR_W)) u_loc_cmp (
    .probe(req_addr), .held(resv_after_snoop), .hit(local_hit)
  );

  llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .snoop_hit(snoop_hit),
    .clr_en   (is_cond || (is_store && local_hit)),
    .set_en   (is_link),
    .set_addr (req_addr),
    .resv_q   (resv_q)
  );

  llsc_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (is_load || is_link),
    .wr_req   (is_store),
    .cond_req (is_cond),
    .cond_pass(local_hit),
    .addr_in  (req_addr),
    .data_in  (req_wdata),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .sc_done  (sc_done),
    .sc_ok    (sc_ok)
  );

  // R6: a conditional always consumes the reservation
  p_cond_consumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_cond |=> (resv_q == '0));

  // R7: with no reservation held, a conditional fails
  p_empty_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && resv_q == '0) |=> (sc_done && !sc_ok && !mem_wr_en));

  // R8: same-cycle snoop on the reserved word defeats the conditional
  p_snoop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && snp_valid && snp_addr == req_addr) |=> (sc_done && !sc_ok));

  // R9: a plain store is always written
  p_store_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> mem_wr_en);
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          mem_rd_en, mem_wr_en, sc_done, sc_ok;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sc_done(sc_done),
    .sc_ok(sc_ok)
  );

  task automatic chk(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Present one cycle of stimulus; outputs are sampled 1 ns after the edge.
  task automatic cyc(input bit v, input int op, input int a, input int d,
                     input bit sv, input int sa);
    @(negedge clk);
    req_valid = v; req_op = op[1:0]; req_addr = a[AW-1:0];
    req_wdata = d[DW-1:0]; snp_valid = sv; snp_addr = sa[AW-1:0];
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic cond_expect(input int a, input int d, input bit exp_ok,
                             input string tag);
    cyc(1, 3, a, d, 0, 0);
    chk(sc_done, 1, {tag, " sc_done"});
    chk(sc_ok, exp_ok, {tag, " sc_ok"});
    chk(mem_wr_en, exp_ok, {tag, " mem_wr_en"});
    if (exp_ok) begin
      chk(mem_addr, a, {tag, " mem_addr"});
      chk(mem_wdata, d, {tag, " mem_wdata"});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(mem_rd_en, 0, "R1 rd_en in reset");
    chk(mem_wr_en, 0, "R1 wr_en in reset");
    chk(sc_done, 0, "R1 sc_done in reset");
    @(negedge clk); rst_n = 1'b1;
    cond_expect(0, 0, 0, "R1 empty after reset");

    // Exhaustive sweep: link r, optional snoop s (16 = none), conditional c.
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s <= 16; s++) begin
        for (int c = 0; c < 16; c++) begin
          bit ok;
          string tag;
          ok = (r != 0) && (c == r) && (s != r);
          if (ok) tag = "R2";
          else if (r == 0) tag = "R7";
          else if (s == r) tag = "R5";
          else tag = "R3";
          cyc(1, 2, r, 0, 0, 0);
          if (s < 16) cyc(0, 0, 0, 0, 1, s);
          cond_expect(c, (r * 7 + c) & 8'hFF, ok, tag);
        end
      end
    end

    // R4 newer link replaces older
    cyc(1, 2, 5, 0, 0, 0);
    cyc(1, 2, 9, 0, 0, 0);
    cond_expect(5, 1, 0, "R4 stale address");
    cyc(1, 2, 5, 0, 0, 0);
    cyc(1, 2, 9, 0, 0, 0);
    cond_expect(9, 2, 1, "R4 newest address");

    // R6 reservation consumed
    cyc(1, 2, 6, 0, 0, 0);
    cond_expect(6, 3, 1, "R6 first conditional");
    cond_expect(6, 4, 0, "R6 second conditional");
    cyc(1, 2, 6, 0, 0, 0);
    cond_expect(7, 3, 0, "R6 failing conditional");
    cond_expect(6, 4, 0, "R6 after failed conditional");

    // R8 same-cycle snoop beats conditional
    cyc(1, 2, 3, 0, 0, 0);
    cyc(1, 3, 3, 5, 1, 3);
    chk(sc_done, 1, "R8 sc_done");
    chk(sc_ok, 0, "R8 sc_ok");
    chk(mem_wr_en, 0, "R8 no write");
    // same-cycle snoop elsewhere does not hurt
    cyc(1, 2, 3, 0, 0, 0);
    cyc(1, 3, 3, 5, 1, 4);
    chk(sc_ok, 1, "R5 unrelated same-cycle snoop");

    // R9 plain stores
    cyc(1, 2, 10, 0, 0, 0);
    cyc(1, 1, 10, 77, 0, 0);
    chk(mem_wr_en, 1, "R9 store writes");
    chk(mem_wdata, 77, "R9 store data");
    chk(sc_done, 0, "R9 store no sc_done");
    cond_expect(10, 1, 0, "R9 store to reserved clears");
    cyc(1, 2, 10, 0, 0, 0);
    cyc(1, 1, 11, 66, 0, 0);
    chk(mem_wr_en, 1, "R9 other store writes");
    cond_expect(10, 2, 1, "R9 store elsewhere keeps");

    // R10 read commands
    cyc(1, 0, 12, 0, 0, 0);
    chk(mem_rd_en, 1, "R10 load rd_en");
    chk(mem_wr_en, 0, "R10 load wr_en");
    chk(sc_done, 0, "R10 load sc_done");
    chk(mem_addr, 12, "R10 load addr");
    cyc(1, 2, 13, 0, 0, 0);
    chk(mem_rd_en, 1, "R10 link rd_en");
    chk(mem_wr_en, 0, "R10 link wr_en");
    chk(sc_done, 0, "R10 link sc_done");
    idle();
    chk(mem_rd_en, 0, "R10 idle rd_en");
    cond_expect(13, 9, 1, "R10 idle keeps link");

    // R11 snoop in same cycle as link does not cancel it
    cyc(1, 2, 14, 0, 1, 14);
    cond_expect(14, 8, 1, "R11 link survives same-cycle snoop");

    // R7 link to zero
    cyc(1, 2, 0, 0, 0, 0);
    cond_expect(0, 1, 0, "R7 zero address");

    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule